// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual byte address into a physical byte address by reading one entry of a page table kept in physical memory. A requester hands over a virtual address together with a read/write flag. The block forms the entry's word address as a base register plus the virtual page number, reads that word over a simple read port and decodes it. The result is either the physical address or a fault code. The physical address is the entry's frame number placed above the untouched page displacement.

Pages and frames are 1 KiB, so the low 10 bits of an address are the displacement. At the default sizes the virtual space holds 32 pages (15-bit addresses) and the physical space holds 8 frames (13-bit addresses). The block works on one request at a time. A missing page is reported as a fault for software to service. Fetching the page, running the handler and caching translations all belong to the surrounding system. The base register is loaded through a separate configuration port, and a write there has effect only while no translation is in progress.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_rd_req` are 0.
- R2: One cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `mem_rd_req` is high for exactly one cycle. At that time `mem_rd_addr` equals the base register plus the virtual page number (`req_vaddr[14:10]`), modulo 2^8.
- R3: While a request is in flight, `req_ready` is 0 and no second strobe is issued. The read may take any number of cycles after the strobe. `rsp_valid` is high for exactly one cycle, in the cycle after the first `mem_rd_valid` that follows the strobe, so each request gets exactly one response.
- R4: Entry layout: bit 0 is valid, bit 1 allows reads, bit 2 allows writes, and bits [5:3] hold the frame number. When the entry is valid and the access is permitted, `rsp_fault` is 0 and `rsp_paddr` is {frame, `req_vaddr[9:0]`}.
- R5: When entry bit 0 is 0, `rsp_fault` is 1 (not present) and `rsp_paddr` is 0, whatever the rights bits hold.
- R6: When the entry is valid but the access lacks permission (a write with bit 2 clear, or a read with bit 1 clear), `rsp_fault` is 2 (protection) and `rsp_paddr` is 0.
- R7: A configuration write (`cfg_we`) loads `cfg_base` into the base register only when no request is in flight. A write made while a request is in flight is dropped, and later walks use the old base.
- R8: A `mem_rd_valid` pulse while no read is outstanding produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Base register write strobe |
| cfg_base | input | 8 | New page table base (word address) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 15 | Virtual byte address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_req | output | 1 | Page table read strobe (one cycle) |
| mem_rd_addr | output | 8 | Word address of the entry |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 8 | Page table entry |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_paddr | output | 13 | Physical byte address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
The bench goes after entries that carry rights bits but no valid bit. A design that checked rights before presence would report a protection fault where a missing page is due. It tests reads of write-only pages and writes of read-only pages, which catches a design that compares the wrong rights bit. It moves the base register mid-walk and also sets a base close enough to the top that the entry address wraps. A design that latched the base late, or carried past 8 bits, would read the wrong word. It also sends stray read-data pulses while idle and stretches read latency to many cycles, which would expose a design that answers twice, answers early, or accepts a second request while busy.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_ABSENT = 2'd1,
      FLT_PROT   = 2'd2
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } walk_st_e;

   // entry bit positions
   localparam int PTE_VALID_BIT = 0;
   localparam int PTE_RD_BIT    = 1;
   localparam int PTE_WR_BIT    = 2;
   localparam int PTE_FRAME_LSB = 3;

endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_data,
   input  logic          idle,
   output logic [AW-1:0] base_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         base_q <= '0;
      else if (wr_en && idle)
         base_q <= wr_data;
   end
endmodule

// File: rtl/pt_index_gen.sv
module pt_index_gen #(
   parameter int VPN_W     = 5,
   parameter int AW        = 8,
   parameter int PTE_SHIFT = 0
) (
   input  logic [AW-1:0]    base,
   input  logic [VPN_W-1:0] vpn,
   output logic [AW-1:0]    addr
);
   generate
      if (PTE_SHIFT == 0) begin : g_unit
         assign addr = base + AW'(vpn);
      end else begin : g_scaled
         assign addr = base + AW'({vpn, {PTE_SHIFT{1'b0}}});
      end
   endgenerate
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
   import pt_walk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic rd_valid,
   output logic req_ready,
   output logic accept,
   output logic issue,
   output logic capture
);
   walk_st_e state_q, state_d;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign issue     = (state_q == ST_ISSUE);
   assign capture   = (state_q == ST_WAIT) && rd_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
         ST_ISSUE: state_d = ST_WAIT;
         ST_WAIT:  if (rd_valid) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/pt_pte_eval.sv
module pt_pte_eval
   import pt_walk_pkg::*;
#(
   parameter int PTE_W   = 8,
   parameter int FRAME_W = 3,
   parameter int OFS_W   = 10,
   localparam int PA_W   = FRAME_W + OFS_W,
   localparam int USED_W = PTE_FRAME_LSB + FRAME_W
) (
   input  logic [PTE_W-1:0] pte,
   input  logic             is_write,
   input  logic [OFS_W-1:0] ofs,
   output logic [PA_W-1:0]  paddr,
   output fault_e           fault
);
   logic               present;
   logic               allowed;
   logic [FRAME_W-1:0] frame;

   assign present = pte[PTE_VALID_BIT];
   assign allowed = is_write ? pte[PTE_WR_BIT] : pte[PTE_RD_BIT];
   assign frame   = pte[PTE_FRAME_LSB +: FRAME_W];

   generate
      if (PTE_W > USED_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^pte[PTE_W-1:USED_W];
      end
   endgenerate

   // presence is decided before rights
   always_comb begin
      if (!present) begin
         fault = FLT_ABSENT;
         paddr = '0;
      end else if (!allowed) begin
         fault = FLT_PROT;
         paddr = '0;
      end else begin
         fault = FLT_NONE;
         paddr = {frame, ofs};
      end
   end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walk_pkg::*;
#(
   parameter int VPN_W     = 5,
   parameter int FRAME_W   = 3,
   parameter int OFS_W     = 10,
   parameter int PTE_W     = 8,
   parameter int PT_AW     = 8,
   parameter int PTE_SHIFT = 0,
   localparam int VA_W     = VPN_W + OFS_W,
   localparam int PA_W     = FRAME_W + OFS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [PT_AW-1:0] cfg_base,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   output logic             mem_rd_req,
   output logic [PT_AW-1:0] mem_rd_addr,
   input  logic             mem_rd_valid,
   input  logic [PTE_W-1:0] mem_rd_data,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic [1:0]       rsp_fault
);
   generate
      if (PTE_W < PTE_FRAME_LSB + FRAME_W) begin : g_bad_pte
         initial $fatal(1, "entry too narrow for frame field");
      end
      if (VPN_W + PTE_SHIFT > PT_AW) begin : g_bad_index
         initial $fatal(1, "table index wider than table address");
      end
      if (OFS_W < 1 || VPN_W < 1 || FRAME_W < 1) begin : g_bad_width
         initial $fatal(1, "address fields must be non-empty");
      end
   endgenerate

   logic             accept, issue, capture;
   logic [PT_AW-1:0] base_q;
   logic [VPN_W-1:0] vpn_q;
   logic [OFS_W-1:0] ofs_q;
   logic             wr_q;
   logic [PA_W-1:0]  eval_paddr;
   fault_e           eval_fault;

   pt_walk_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .rd_valid  (mem_rd_valid),
      .req_ready (req_ready),
      .accept    (accept),
      .issue     (issue),
      .capture   (capture)
   );

   pt_base_reg #(.AW(PT_AW)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_data (cfg_base),
      .idle    (req_ready),
      .base_q  (base_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q <= '0;
         ofs_q <= '0;
         wr_q  <= 1'b0;
      end else if (accept) begin
         vpn_q <= req_vaddr[VA_W-1:OFS_W];
         ofs_q <= req_vaddr[OFS_W-1:0];
         wr_q  <= req_write;
      end
   end

   pt_index_gen #(.VPN_W(VPN_W), .AW(PT_AW), .PTE_SHIFT(PTE_SHIFT)) u_idx (
      .base (base_q),
      .vpn  (vpn_q),
      .addr (mem_rd_addr)
   );

   assign mem_rd_req = issue;

   pt_pte_eval #(.PTE_W(PTE_W), .FRAME_W(FRAME_W), .OFS_W(OFS_W)) u_eval (
      .pte      (mem_rd_data),
      .is_write (wr_q),
      .ofs      (ofs_q),
      .paddr    (eval_paddr),
      .fault    (eval_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= 2'd0;
      end else begin
         rsp_valid <= capture;
         if (capture) begin
            rsp_paddr <= eval_paddr;
            rsp_fault <= 2'(eval_fault);
         end
      end
   end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int VA_W  = 15,
   parameter int OFS_W = 10,
   parameter int PA_W  = 13
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_vaddr,
   input logic            mem_rd_req,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_paddr,
   input logic [1:0]      rsp_fault
);
   logic             busy_q;
   logic [OFS_W-1:0] ofs_q;
   logic             unused_va;

   assign unused_va = ^req_vaddr[VA_W-1:OFS_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ofs_q  <= '0;
      end else if (req_valid && req_ready) begin
         busy_q <= 1'b1;
         ofs_q  <= req_vaddr[OFS_W-1:0];
      end else if (rsp_valid) begin
         busy_q <= 1'b0;
      end
   end

   assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);

   assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_rsp_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> busy_q);

   assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 2'd0) |-> rsp_paddr[OFS_W-1:0] == ofs_q);

   assert_fault_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_fault != 2'd3);

   assert_fault_zero_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0);
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_vaddr (req_vaddr),
   .mem_rd_req(mem_rd_req),
   .rsp_valid (rsp_valid),
   .rsp_paddr (rsp_paddr),
   .rsp_fault (rsp_fault)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_base = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [14:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        mem_rd_req;
   logic [7:0]  mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [7:0]  mem_rd_data = '0;
   logic        rsp_valid;
   logic [12:0] rsp_paddr;
   logic [1:0]  rsp_fault;

   int checks = 0;
   int fails  = 0;
   logic [7:0]  base_sw = '0;
   logic [14:0] exp_q[$];

   always #4 clk = ~clk;

   pt_walker u0 (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // monitor: compare each response against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            chk(0, "R8 unexpected response", {rsp_fault, rsp_paddr}, 0);
         end else begin
            logic [14:0] e;
            e = exp_q.pop_front();
            chk({rsp_fault, rsp_paddr} == e, "R4/R5/R6 response", {rsp_fault, rsp_paddr}, e);
         end
      end
   end

   task automatic walk(input int page, input int ofs, input bit wr,
                       input bit v, input bit r, input bit w, input int frame,
                       input int lat, input bit poke_cfg);
      logic [7:0]  pte;
      logic [7:0]  eaddr;
      logic [14:0] e;
      pte = 8'((frame << 3) | (w << 2) | (r << 1) | v);
      if (!v)                    e = {2'd1, 13'd0};
      else if (wr ? !w : !r)     e = {2'd2, 13'd0};
      else                       e = {2'd0, 3'(frame), 10'(ofs)};
      eaddr = 8'(base_sw + 8'(page));
      @(negedge clk);
      chk(req_ready == 1'b1, "R3 ready when idle", req_ready, 1);
      req_valid = 1'b1;
      req_vaddr = {5'(page), 10'(ofs)};
      req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_rd_req == 1'b1, "R2 strobe after accept", mem_rd_req, 1);
      chk(mem_rd_addr == eaddr, "R2 entry address", mem_rd_addr, eaddr);
      exp_q.push_back(e);
      if (poke_cfg) begin
         cfg_we = 1'b1;
         cfg_base = 8'h40;
      end
      @(negedge clk);
      cfg_we = 1'b0;
      chk(mem_rd_req == 1'b0, "R2 strobe single cycle", mem_rd_req, 0);
      for (int i = 0; i < lat; i++) begin
         chk(req_ready == 1'b0 && rsp_valid == 1'b0, "R3 busy while waiting",
             {req_ready, rsp_valid}, 0);
         @(negedge clk);
      end
      mem_rd_valid = 1'b1;
      mem_rd_data  = pte;
      @(negedge clk);
      mem_rd_valid = 1'b0;
      mem_rd_data  = '0;
      chk(rsp_valid == 1'b1, "R3 response one cycle after data", rsp_valid, 1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R3 response single cycle", rsp_valid, 0);
   endtask

   task automatic set_base(input logic [7:0] b);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_base = b;
      @(negedge clk);
      cfg_we = 1'b0;
      base_sw = b;
   endtask

   bit done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
      chk(mem_rd_req == 1'b0, "R1 no strobe after reset", mem_rd_req, 0);

      set_base(8'h10);
      walk(3, 10'h155, 0, 1, 1, 0, 5, 0, 0);     // R4 read permitted
      walk(31, 10'h3FF, 1, 1, 0, 1, 7, 3, 0);    // R4 write permitted, max page
      walk(0, 0, 0, 1, 1, 1, 0, 1, 0);           // R4 page 0 frame 0
      walk(7, 10'h0AA, 0, 0, 1, 1, 6, 1, 0);     // R5 not present with rights set
      walk(9, 10'h001, 1, 0, 0, 0, 2, 2, 0);     // R5 not present, write
      walk(12, 10'h200, 1, 1, 1, 0, 4, 0, 0);    // R6 write to read-only
      walk(13, 10'h300, 0, 1, 0, 1, 3, 5, 0);    // R6 read of write-only
      walk(5, 10'h123, 0, 1, 1, 0, 1, 4, 1);     // R7 cfg write while busy
      walk(6, 10'h321, 1, 1, 1, 1, 2, 0, 0);     // R7 old base still in use
      set_base(8'hF8);
      walk(20, 10'h0F0, 0, 1, 1, 0, 6, 20, 0);   // R7 new base, address wraps
      // R8 stray read data while idle
      @(negedge clk);
      mem_rd_valid = 1'b1;
      mem_rd_data = 8'hFF;
      @(negedge clk);
      mem_rd_valid = 1'b0;
      chk(rsp_valid == 1'b0, "R8 stray data ignored", rsp_valid, 0);
      chk(req_ready == 1'b1, "R8 still idle", req_ready, 1);
      walk(1, 10'h2AB, 1, 1, 0, 1, 1, 60, 0);    // R3 long latency
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R3 one response per request", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule